// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block orders the shutdown and restart of a clock generator's output groups and its analog sources. A board-level sleep request arrives asynchronously and active low; it is resynchronized before anything acts on it. On entry the six output-group gate enables (processor, peripheral bus, graphics port, memory, reference and 48 MHz) drop together and are held low for a parking window. Only after that window closes is the VCO enable removed, and one cycle later the crystal oscillator enable. The oscillator and PLL are represented only by these two enables.

When the request is withdrawn, the oscillator comes back first, the VCO one cycle later, and the outputs stay parked while a count of slow timer ticks runs. When the count expires, all group enables rise together in one registered step. The count and tick period are parameters, chosen so that the wake-up fits a 3 ms budget. A mode strap sampled during reset selects whether the request and the two stop inputs are honoured at all. The processor and peripheral stop inputs gate their groups only while the sequencer is running normally.

Top module: `pwr_down_seq`

## Requirements
- R1: The sleep request passes through a two-stage synchronizer. After it goes low, all six group enables go low together on the fourth rising clock edge, and none of them changes earlier.
- R2: Once the groups are low, the VCO enable stays high for PARK_CYC cycles and then falls. The oscillator enable falls exactly one cycle after the VCO enable.
- R3: While the VCO enable is low, every group enable is low. While the oscillator enable is low, the VCO enable is low.
- R4: The group enables stay low with both analog enables low until the request is released.
- R5: With strap 0 in normal running, a low on a stop input clears its group enable (cpu_halt_n for cpu_gate_en, pci_halt_n for pci_gate_en) on the third rising edge. The stop inputs have no effect anywhere in the power-down sequence.
- R6: The mode strap is captured while rst is high and held afterwards. With a captured 1, the sleep request and both stop inputs are ignored and all enables stay high. Changes of the strap pin after reset have no effect.
- R7: On release, the oscillator enable rises on the fourth edge after the request goes high and the VCO enable rises one cycle later. The groups stay low until SETTLE_TICKS slow ticks have been counted, then all six rise in the same cycle.
- R8: With default parameters, the time from release of the request to the groups running again, counted in ticks of TICK_NS, stays below 3 ms.
- R9: After reset, all eight enables are high.
- R10: If the request is withdrawn part-way through shutdown, the shutdown still completes, with the oscillator turned off, before the wake-up sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock of the sequencer |
| rst | input | 1 | Synchronous active-high reset; the strap is sampled while it is high |
| mode_strap | input | 1 | 1 = request and stop inputs ignored, 0 = power management honoured |
| sleep_req_n | input | 1 | Asynchronous active-low power-down request |
| cpu_halt_n | input | 1 | Asynchronous active-low processor-group stop |
| pci_halt_n | input | 1 | Asynchronous active-low peripheral-group stop |
| slow_tick | input | 1 | Single-cycle pulse from a free-running slow timer |
| cpu_gate_en | output | 1 | Processor clock group enable |
| pci_gate_en | output | 1 | Peripheral bus clock group enable |
| agp_gate_en | output | 1 | Graphics port clock group enable |
| mem_gate_en | output | 1 | Memory clock group enable |
| ref_gate_en | output | 1 | Reference clock output enable |
| usb_gate_en | output | 1 | 48 MHz output enable |
| vco_en | output | 1 | PLL VCO enable |
| osc_en | output | 1 | Crystal oscillator enable |

## Verification
The assertions assume the following about the inputs:
- slow_tick is a single-cycle pulse synchronous to clk.
- The strap is stable while rst is high.
- The request, once asserted, is held long enough for the synchronizer to see it.

The stimulus drives every input on the falling edge and generates the tick as one pulse every ten clocks. It keeps the strap fixed through each reset and changes it only afterwards, to show that late changes are ignored. Requests and stop pulses each last several cycles, including a request withdrawn in the middle of the parking window.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_PARK     = 3'd1,
        ST_VCO_OFF  = 3'd2,
        ST_XTAL_OFF = 3'd3,
        ST_ASLEEP   = 3'd4,
        ST_XTAL_ON  = 3'd5,
        ST_SETTLE   = 3'd6,
        ST_RELEASE  = 3'd7
    } pd_state_e;

    typedef struct packed {
        logic cpu;
        logic pci;
        logic agp;
        logic mem;
        logic refc;
        logic usb;
        logic vco;
        logic osc;
    } gate_vec_t;

    localparam gate_vec_t GATES_ALL_ON = '{1'b1, 1'b1, 1'b1, 1'b1,
                                           1'b1, 1'b1, 1'b1, 1'b1};

    function automatic gate_vec_t state_gates(pd_state_e st,
                                              logic cpu_ok,
                                              logic pci_ok);
        gate_vec_t g;
        g = '0;
        case (st)
            ST_RUN, ST_RELEASE: begin
                g     = GATES_ALL_ON;
                g.cpu = cpu_ok;
                g.pci = pci_ok;
            end
            ST_PARK, ST_SETTLE: begin
                g.vco = 1'b1;
                g.osc = 1'b1;
            end
            ST_VCO_OFF, ST_XTAL_ON: begin
                g.osc = 1'b1;
            end
            default: g = '0;
        endcase
        return g;
    endfunction

    function automatic int cnt_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pds_sync.sv
module pds_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= RST_VAL;
                    else     stage_q[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= RST_VAL;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pds_strap.sv
module pds_strap (
    input  logic clk,
    input  logic rst,
    input  logic strap,
    output logic strap_q
);
    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap;
    end
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
#(
    parameter int PARK_CYC     = 4,
    parameter int SETTLE_TICKS = 20
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep_req,
    input  logic      slow_tick,
    output pd_state_e state
);
    localparam int PW = cnt_width(PARK_CYC);
    localparam int TW = cnt_width(SETTLE_TICKS);
    localparam logic [PW-1:0] PARK_LAST   = PW'(PARK_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_TICKS - 1);

    pd_state_e      st_q, st_d;
    logic [PW-1:0]  park_q, park_d;
    logic [TW-1:0]  tick_q, tick_d;

    always_comb begin
        st_d   = st_q;
        park_d = park_q;
        tick_d = tick_q;
        case (st_q)
            ST_RUN: begin
                park_d = '0;
                if (sleep_req) st_d = ST_PARK;
            end
            ST_PARK: begin
                if (park_q == PARK_LAST) st_d = ST_VCO_OFF;
                else                     park_d = park_q + 1'b1;
            end
            ST_VCO_OFF:  st_d = ST_XTAL_OFF;
            ST_XTAL_OFF: st_d = ST_ASLEEP;
            ST_ASLEEP: begin
                if (!sleep_req) st_d = ST_XTAL_ON;
            end
            ST_XTAL_ON: begin
                tick_d = '0;
                st_d   = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (slow_tick) begin
                    if (tick_q == SETTLE_LAST) st_d = ST_RELEASE;
                    else                       tick_d = tick_q + 1'b1;
                end
            end
            ST_RELEASE:  st_d = ST_RUN;
            default:     st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_RUN;
            park_q <= '0;
            tick_q <= '0;
        end else begin
            st_q   <= st_d;
            park_q <= park_d;
            tick_q <= tick_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/pds_gate_reg.sv
module pds_gate_reg
    import pds_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pd_state_e state,
    input  logic      cpu_ok,
    input  logic      pci_ok,
    output gate_vec_t gates
);
    gate_vec_t gates_q;

    always_ff @(posedge clk) begin
        if (rst) gates_q <= GATES_ALL_ON;
        else     gates_q <= state_gates(state, cpu_ok, pci_ok);
    end

    assign gates = gates_q;
endmodule

// File: rtl/pwr_down_seq.sv
module pwr_down_seq
    import pds_pkg::*;
#(
    parameter int PARK_CYC     = 4,
    parameter int SETTLE_TICKS = 20,
    parameter int TICK_NS      = 100000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_strap,
    input  logic sleep_req_n,
    input  logic cpu_halt_n,
    input  logic pci_halt_n,
    input  logic slow_tick,
    output logic cpu_gate_en,
    output logic pci_gate_en,
    output logic agp_gate_en,
    output logic mem_gate_en,
    output logic ref_gate_en,
    output logic usb_gate_en,
    output logic vco_en,
    output logic osc_en
);
    localparam int SETTLE_NS_MAX = SETTLE_TICKS * TICK_NS;

    logic [2:0] async_in, synced;
    logic       mode_lat;
    logic       sleep_req;
    logic       cpu_ok, pci_ok;
    pd_state_e  state;
    gate_vec_t  gates;

    assign async_in = {sleep_req_n, cpu_halt_n, pci_halt_n};

    pds_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (async_in),
        .q   (synced)
    );

    pds_strap u_strap (
        .clk     (clk),
        .rst     (rst),
        .strap   (mode_strap),
        .strap_q (mode_lat)
    );

    assign sleep_req = !synced[2] && !mode_lat;
    assign cpu_ok    = mode_lat || synced[1];
    assign pci_ok    = mode_lat || synced[0];

    pds_fsm #(.PARK_CYC(PARK_CYC), .SETTLE_TICKS(SETTLE_TICKS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .slow_tick (slow_tick),
        .state     (state)
    );

    pds_gate_reg u_gates (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .cpu_ok (cpu_ok),
        .pci_ok (pci_ok),
        .gates  (gates)
    );

    assign cpu_gate_en = gates.cpu;
    assign pci_gate_en = gates.pci;
    assign agp_gate_en = gates.agp;
    assign mem_gate_en = gates.mem;
    assign ref_gate_en = gates.refc;
    assign usb_gate_en = gates.usb;
    assign vco_en      = gates.vco;
    assign osc_en      = gates.osc;
endmodule

// File: rtl/pwr_down_seq_chk.sv
module pwr_down_seq_chk (
    input logic clk,
    input logic rst,
    input logic mode_lat,
    input logic sleep_req_n,
    input logic cpu_gate_en,
    input logic pci_gate_en,
    input logic agp_gate_en,
    input logic mem_gate_en,
    input logic ref_gate_en,
    input logic usb_gate_en,
    input logic vco_en,
    input logic osc_en
);
    logic [3:0] grp;
    assign grp = {agp_gate_en, mem_gate_en, ref_gate_en, usb_gate_en};

    a_r1_fall_needs_request: assert property (@(posedge clk) disable iff (rst)
        $fell(agp_gate_en) |-> !$past(sleep_req_n, 3));

    a_r2_vco_fall_after_park: assert property (@(posedge clk) disable iff (rst)
        $fell(vco_en) |-> ($past(grp) == 4'b0000));

    a_r2_osc_fall_after_vco: assert property (@(posedge clk) disable iff (rst)
        $fell(osc_en) |-> !$past(vco_en));

    a_r3_vco_off_groups_low: assert property (@(posedge clk) disable iff (rst)
        !vco_en |-> (grp == 4'b0000 && !cpu_gate_en && !pci_gate_en));

    a_r3_osc_off_vco_off: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> !vco_en);

    a_r7_osc_rises_alone: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_en) |-> !vco_en);

    a_r7_groups_rise_together: assert property (@(posedge clk) disable iff (rst)
        $rose(agp_gate_en) |-> (grp == 4'b1111 && vco_en && osc_en));

    a_r6_strap_keeps_running: assert property (@(posedge clk) disable iff (rst)
        mode_lat |-> (osc_en && vco_en && cpu_gate_en && pci_gate_en));
endmodule

bind pwr_down_seq pwr_down_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_lat    (mode_lat),
    .sleep_req_n (sleep_req_n),
    .cpu_gate_en (cpu_gate_en),
    .pci_gate_en (pci_gate_en),
    .agp_gate_en (agp_gate_en),
    .mem_gate_en (mem_gate_en),
    .ref_gate_en (ref_gate_en),
    .usb_gate_en (usb_gate_en),
    .vco_en      (vco_en),
    .osc_en      (osc_en)
);

// File: tb/pwr_down_seq_test.sv
`timescale 1ns/1ps
module pwr_down_seq_test;
    localparam int PARK = 4;
    localparam int SETTLE = 20;
    localparam int TICK_DIV = 10;
    localparam int CLK_NS = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_strap = 1'b0;
    logic sleep_req_n = 1'b1;
    logic cpu_halt_n = 1'b1;
    logic pci_halt_n = 1'b1;
    logic slow_tick = 1'b0;
    logic cpu_gate_en, pci_gate_en, agp_gate_en, mem_gate_en;
    logic ref_gate_en, usb_gate_en, vco_en, osc_en;

    int n_tests = 0;
    int n_fail = 0;
    string cur_req = "R9";
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    pwr_down_seq #(.PARK_CYC(PARK), .SETTLE_TICKS(SETTLE)) uut (
        .clk(clk), .rst(rst), .mode_strap(mode_strap),
        .sleep_req_n(sleep_req_n), .cpu_halt_n(cpu_halt_n),
        .pci_halt_n(pci_halt_n), .slow_tick(slow_tick),
        .cpu_gate_en(cpu_gate_en), .pci_gate_en(pci_gate_en),
        .agp_gate_en(agp_gate_en), .mem_gate_en(mem_gate_en),
        .ref_gate_en(ref_gate_en), .usb_gate_en(usb_gate_en),
        .vco_en(vco_en), .osc_en(osc_en)
    );

    function automatic logic [7:0] dut_vec();
        return {cpu_gate_en, pci_gate_en, agp_gate_en, mem_gate_en,
                ref_gate_en, usb_gate_en, vco_en, osc_en};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // tick generator: one pulse every TICK_DIV clocks
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        slow_tick = (tdiv == 0);
    end

    // behavioural reference model
    logic [7:0] m_out;
    int phase;          // 0 run,1 park,2 vco off,3 xtal off,4 asleep,5 xtal on,6 settle,7 release
    int park_n, tick_n;
    bit m_mode;
    bit hist_req[$], hist_cpu[$], hist_pci[$];

    function automatic logic [7:0] phase_out(int p, bit c, bit q);
        logic [7:0] v;
        v = 8'h00;
        if (p == 0 || p == 7) v = {c, q, 6'b111111};
        else if (p == 1 || p == 6) v = 8'b0000_0011;
        else if (p == 2 || p == 5) v = 8'b0000_0001;
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = mode_strap;
            phase = 0; park_n = 0; tick_n = 0;
            m_out = 8'hFF;
            hist_req = '{1'b1, 1'b1};
            hist_cpu = '{1'b1, 1'b1};
            hist_pci = '{1'b1, 1'b1};
        end else begin
            bit r_s, c_s, p_s, want;
            r_s = hist_req[0]; c_s = hist_cpu[0]; p_s = hist_pci[0];
            want = !r_s && !m_mode;
            m_out = phase_out(phase, m_mode || c_s, m_mode || p_s);
            case (phase)
                0: begin park_n = 0; if (want) phase = 1; end
                1: begin if (park_n == PARK - 1) phase = 2; else park_n++; end
                2: phase = 3;
                3: phase = 4;
                4: if (!want) phase = 5;
                5: begin tick_n = 0; phase = 6; end
                6: if (slow_tick) begin
                       if (tick_n == SETTLE - 1) phase = 7; else tick_n++;
                   end
                default: phase = 0;
            endcase
            void'(hist_req.pop_front()); hist_req.push_back(sleep_req_n);
            void'(hist_cpu.pop_front()); hist_cpu.push_back(cpu_halt_n);
            void'(hist_pci.pop_front()); hist_pci.push_back(pci_halt_n);
        end
    end

    always @(negedge clk) begin
        if (cmp_on) check(cur_req, dut_vec(), m_out, "model compare");
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(bit strap);
        @(negedge clk);
        cmp_on = 1'b0;
        rst = 1'b1; mode_strap = strap;
        sleep_req_n = 1'b1; cpu_halt_n = 1'b1; pci_halt_n = 1'b1;
        cycles(3);
        rst = 1'b0;
        cycles(1);
        cmp_on = 1'b1;
    endtask

    initial begin
        #(longint'(200000) * CLK_NS);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int k, k_osc, k_vco, k_grp;
        bit saw_off;

        // R9 reset state
        do_reset(1'b0);
        cur_req = "R9";
        check("R9", dut_vec(), 8'hFF, "reset state");

        // R5 stop inputs in normal running
        cur_req = "R5";
        cpu_halt_n = 1'b0;
        cycles(2);
        check("R5", {7'b0, cpu_gate_en}, 8'd1, "cpu before 3rd edge");
        cycles(1);
        check("R5", {7'b0, cpu_gate_en}, 8'd0, "cpu stop at 3rd edge");
        cpu_halt_n = 1'b1; pci_halt_n = 1'b0;
        cycles(3);
        check("R5", {6'b0, cpu_gate_en, pci_gate_en}, 8'b10, "pci stop");
        pci_halt_n = 1'b1;
        cycles(4);

        // R1 entry timing
        cur_req = "R1";
        sleep_req_n = 1'b0;
        k = 0;
        do begin cycles(1); k++; end while (agp_gate_en && k < 20);
        check("R1", 8'(k), 8'd4, "edges to group stop");
        check("R1", dut_vec(), 8'b0000_0011, "all groups low together");

        // R2 ordering
        cur_req = "R2";
        cycles(PARK - 1);
        check("R2", {7'b0, vco_en}, 8'd1, "vco held during park");
        cycles(1);
        check("R2", {6'b0, vco_en, osc_en}, 8'b01, "vco off, osc on");
        cycles(1);
        check("R2", {6'b0, vco_en, osc_en}, 8'b00, "osc off next cycle");

        // R4/R5 held asleep, stop inputs ignored
        cur_req = "R4";
        cpu_halt_n = 1'b0; pci_halt_n = 1'b0;
        cycles(10);
        cpu_halt_n = 1'b1; pci_halt_n = 1'b1;
        cycles(10);
        check("R4", dut_vec(), 8'h00, "asleep, stop toggles ignored (R5)");

        // R7/R8 wake
        cur_req = "R7";
        sleep_req_n = 1'b1;
        k = 0; k_osc = 0; k_vco = 0; k_grp = 0;
        do begin
            cycles(1); k++;
            if (osc_en && k_osc == 0) k_osc = k;
            if (vco_en && k_vco == 0) k_vco = k;
            if (agp_gate_en && k_grp == 0) k_grp = k;
        end while (k_grp == 0 && k < 1000);
        check("R7", 8'(k_osc), 8'd4, "osc rises 4th edge");
        check("R7", 8'(k_vco), 8'd5, "vco one cycle later");
        check("R7", dut_vec(), 8'hFF, "groups rise together");
        n_tests++;
        if (k_grp <= (SETTLE - 1) * TICK_DIV) begin
            n_fail++;
            $display("FAIL R7 settle too short: actual %0d expected > %0d", k_grp, (SETTLE - 1) * TICK_DIV);
        end
        n_tests++;
        if ((k_grp / TICK_DIV) * 100000 >= 3000000) begin
            n_fail++;
            $display("FAIL R8 wake latency: actual %0d ticks expected < 30", k_grp / TICK_DIV);
        end
        cycles(5);

        // R10 request withdrawn during park
        cur_req = "R10";
        sleep_req_n = 1'b0;
        cycles(5);
        sleep_req_n = 1'b1;
        saw_off = 1'b0;
        k = 0;
        do begin
            cycles(1); k++;
            if (!osc_en) saw_off = 1'b1;
        end while (!(saw_off && agp_gate_en) && k < 1000);
        check("R10", {7'b0, saw_off}, 8'd1, "oscillator went off");
        check("R10", dut_vec(), 8'hFF, "woke afterwards");

        // R6 strap 1: request and stops ignored, late strap change ignored
        do_reset(1'b1);
        cur_req = "R6";
        mode_strap = 1'b0;
        sleep_req_n = 1'b0; cpu_halt_n = 1'b0; pci_halt_n = 1'b0;
        cycles(40);
        check("R6", dut_vec(), 8'hFF, "strap 1 ignores request and stops");
        sleep_req_n = 1'b1; cpu_halt_n = 1'b1; pci_halt_n = 1'b1;
        cycles(3);

        cmp_on = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule